// File: doc/BRIEF.md
# Host Event Pending and Query Unit

This unit keeps a vector of pending host events along with three independent enable masks. One mask drives the system-management interrupt request, one drives the system-control interrupt request and one drives the wake request. Local logic raises an event by presenting its code together with a strobe. Event codes start at 1, so that the value 0 can mean "no event".

The host side reaches the unit through strobes that an upstream command decoder has already produced. With these strobes the host can write and read any of the masks, clear a set of pending events by giving a bit mask, and run a query. A query returns the 1-based index of the lowest pending event and retires that event only.

Each request output is registered and stays asserted while at least one pending event is enabled in its mask. The mailbox also uses these outputs as its interrupt-pending status bits.

Top module: `hev_unit`

## Requirements
- R1: After a synchronous reset, all pending bits and all three masks are zero. `smi_req`, `sci_req`, `wake_req`, `qry_done`, `qry_code` and `mask_rdata` are all 0.
- R2: A raise strobe with code n, where 1 <= n <= NEV, sets pending bit n-1 at the clock edge. A raise with code 0 or with a code above NEV is ignored.
- R3: When `mask_wr` is high, `mask_wdata` is written to the mask chosen by `mask_sel`: 0 selects the SMI mask, 1 the SCI mask, 2 the wake mask, and 3 selects nothing, so the write has no effect. `mask_rdata` shows the mask chosen by `mask_rsel` one cycle after it is sampled, and shows 0 when the select is 3.
- R4: A clear strobe removes every pending bit that is set in `clr_bits` and leaves all other pending bits unchanged.
- R5: A query strobe retires only the lowest-numbered pending bit. One cycle later, `qry_done` pulses high for a single cycle and `qry_code` carries that bit's index plus one.
- R6: A query while nothing is pending returns code 0 and changes no state.
- R7: Each request output (`smi_req`, `sci_req`, `wake_req`) is high when the bitwise AND of the pending bits and its own mask is nonzero. It is updated at the same clock edge as the state it depends on.
- R8: When an event is raised in the same cycle as a clear or a query that would retire that same bit, the raise wins and the bit stays pending.
- R9: Pending bit NEV-1 is reported by a query as code NEV (32 by default).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| raise_vld | input | 1 | Raise strobe from local logic |
| raise_code | input | CW | 1-based event code to raise |
| clr_vld | input | 1 | Clear strobe from host |
| clr_bits | input | NEV | Pending bits to clear |
| qry_vld | input | 1 | Query strobe from host |
| mask_wr | input | 1 | Mask write strobe |
| mask_sel | input | 2 | Mask chosen for write (0 SMI, 1 SCI, 2 wake, 3 none) |
| mask_wdata | input | NEV | Mask write value |
| mask_rsel | input | 2 | Mask chosen for readback, same encoding |
| mask_rdata | output | NEV | Registered mask readback |
| qry_done | output | 1 | One-cycle pulse carrying a query result |
| qry_code | output | CW | Query result, 0 when nothing pending |
| smi_req | output | 1 | SMI request / SMI pending status |
| sci_req | output | 1 | SCI request / SCI pending status |
| wake_req | output | 1 | Wake request |

## Verification
The bench builds the unit with its defaults: NEV = 32 events and a code width of 6. At this size the top pending bit, which must answer as code 32, can be reached. Codes 33 to 63 fit in the code field, so they can be driven and shown to have no effect. Pending contents are observed only through the ports: the bench drains the pending vector by repeated queries and watches the request outputs under chosen masks. This covers query ordering across several raised codes, clears by mask, the mask select that selects nothing, and raise-versus-retire collisions on the same bit.

// File: rtl/hev_pkg.sv
package hev_pkg;
  typedef enum logic [1:0] {
    SEL_SMI  = 2'd0,
    SEL_SCI  = 2'd1,
    SEL_WAKE = 2'd2,
    SEL_NONE = 2'd3
  } mask_sel_e;

  localparam int NUM_MASKS = 3;
endpackage

// File: rtl/hev_lowest.sv
module hev_lowest #(
  parameter int NEV = 32,
  parameter int CW  = $clog2(NEV + 1)
) (
  input  logic [NEV-1:0] vec,
  output logic [CW-1:0]  code,
  output logic [NEV-1:0] onehot
);
  always_comb begin
    code   = '0;
    onehot = '0;
    for (int i = NEV - 1; i >= 0; i--) begin
      if (vec[i]) begin
        code   = CW'(i + 1);
        onehot = '0;
        onehot[i] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/hev_masks.sv
module hev_masks
  import hev_pkg::*;
#(
  parameter int NEV = 32
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           wr,
  input  logic [1:0]                     sel,
  input  logic [NEV-1:0]                 wdata,
  output logic [NUM_MASKS-1:0][NEV-1:0]  masks_q,
  output logic [NUM_MASKS-1:0][NEV-1:0]  masks_d
);
  for (genvar m = 0; m < NUM_MASKS; m++) begin : g_mask
    always_comb masks_d[m] = (wr && sel == 2'(m)) ? wdata : masks_q[m];

    always_ff @(posedge clk) begin
      if (rst) masks_q[m] <= '0;
      else     masks_q[m] <= masks_d[m];
    end

    p_mask_write_r3: assert property (@(posedge clk) disable iff (rst)
      (wr && sel == 2'(m)) |=> (masks_q[m] == $past(wdata)));
    p_mask_hold_r3: assert property (@(posedge clk) disable iff (rst)
      (!(wr && sel == 2'(m))) |=> $stable(masks_q[m]));
  end
endmodule

// File: rtl/hev_pending.sv
module hev_pending #(
  parameter int NEV = 32,
  parameter int CW  = $clog2(NEV + 1)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           raise_vld,
  input  logic [CW-1:0]  raise_code,
  input  logic           clr_vld,
  input  logic [NEV-1:0] clr_bits,
  input  logic [NEV-1:0] qry_take,
  output logic [NEV-1:0] pend_q,
  output logic [NEV-1:0] pend_d
);
  logic [NEV-1:0] raise_m;
  logic [NEV-1:0] clr_m;

  for (genvar i = 0; i < NEV; i++) begin : g_dec
    assign raise_m[i] = raise_vld && (raise_code == CW'(i + 1));
  end

  assign clr_m  = clr_vld ? clr_bits : '0;
  assign pend_d = (pend_q & ~clr_m & ~qry_take) | raise_m;

  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else     pend_q <= pend_d;
  end

  p_raise_wins_r8: assert property (@(posedge clk) disable iff (rst)
    (raise_m != '0) |=> ((pend_q & $past(raise_m)) == $past(raise_m)));
  p_clear_bits_r4: assert property (@(posedge clk) disable iff (rst)
    (clr_vld && raise_m == '0) |=> ((pend_q & $past(clr_bits)) == '0));
  p_one_per_query_r5: assert property (@(posedge clk) disable iff (rst)
    (!clr_vld) |=> ($countones(pend_q) + 1 >= $countones($past(pend_q))));
  p_take_onehot_r5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(qry_take));
endmodule

// File: rtl/hev_unit.sv
module hev_unit
  import hev_pkg::*;
#(
  parameter int NEV = 32,
  parameter int CW  = $clog2(NEV + 1)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           raise_vld,
  input  logic [CW-1:0]  raise_code,
  input  logic           clr_vld,
  input  logic [NEV-1:0] clr_bits,
  input  logic           qry_vld,
  input  logic           mask_wr,
  input  logic [1:0]     mask_sel,
  input  logic [NEV-1:0] mask_wdata,
  input  logic [1:0]     mask_rsel,
  output logic [NEV-1:0] mask_rdata,
  output logic           qry_done,
  output logic [CW-1:0]  qry_code,
  output logic           smi_req,
  output logic           sci_req,
  output logic           wake_req
);
  logic [NEV-1:0]                pend_q, pend_d;
  logic [NUM_MASKS-1:0][NEV-1:0] masks_q, masks_d;
  logic [CW-1:0]                 low_code;
  logic [NEV-1:0]                low_onehot;
  logic [NEV-1:0]                qry_take;

  hev_lowest #(.NEV(NEV), .CW(CW)) u_low (
    .vec(pend_q), .code(low_code), .onehot(low_onehot)
  );

  assign qry_take = qry_vld ? low_onehot : '0;

  hev_pending #(.NEV(NEV), .CW(CW)) u_pend (
    .clk(clk), .rst(rst), .raise_vld(raise_vld), .raise_code(raise_code),
    .clr_vld(clr_vld), .clr_bits(clr_bits), .qry_take(qry_take),
    .pend_q(pend_q), .pend_d(pend_d)
  );

  hev_masks #(.NEV(NEV)) u_masks (
    .clk(clk), .rst(rst), .wr(mask_wr), .sel(mask_sel), .wdata(mask_wdata),
    .masks_q(masks_q), .masks_d(masks_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      qry_done   <= 1'b0;
      qry_code   <= '0;
      mask_rdata <= '0;
      smi_req    <= 1'b0;
      sci_req    <= 1'b0;
      wake_req   <= 1'b0;
    end else begin
      qry_done   <= qry_vld;
      qry_code   <= qry_vld ? low_code : '0;
      mask_rdata <= (mask_rsel == SEL_NONE) ? '0 : masks_q[mask_rsel];
      smi_req    <= |(pend_d & masks_d[SEL_SMI]);
      sci_req    <= |(pend_d & masks_d[SEL_SCI]);
      wake_req   <= |(pend_d & masks_d[SEL_WAKE]);
    end
  end

  p_done_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    qry_vld |=> qry_done);
  p_code_range_r5: assert property (@(posedge clk) disable iff (rst)
    qry_done |-> (qry_code <= CW'(NEV)));
  p_empty_query_r6: assert property (@(posedge clk) disable iff (rst)
    (qry_vld && pend_q == '0) |=> (qry_code == '0));
  p_req_idle_r7: assert property (@(posedge clk) disable iff (rst)
    (pend_q == '0) |-> !(smi_req || sci_req || wake_req));
endmodule

// File: tb/sim_hev_unit.sv
`timescale 1ns/1ps
module sim_hev_unit;
  localparam int NEV = 32;
  localparam int CW  = 6;

  logic           clk = 1'b0;
  logic           rst;
  logic           raise_vld;
  logic [CW-1:0]  raise_code;
  logic           clr_vld;
  logic [NEV-1:0] clr_bits;
  logic           qry_vld;
  logic           mask_wr;
  logic [1:0]     mask_sel;
  logic [NEV-1:0] mask_wdata;
  logic [1:0]     mask_rsel;
  logic [NEV-1:0] mask_rdata;
  logic           qry_done;
  logic [CW-1:0]  qry_code;
  logic           smi_req, sci_req, wake_req;

  int n_run  = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  hev_unit #(.NEV(NEV), .CW(CW)) u0 (
    .clk(clk), .rst(rst), .raise_vld(raise_vld), .raise_code(raise_code),
    .clr_vld(clr_vld), .clr_bits(clr_bits), .qry_vld(qry_vld),
    .mask_wr(mask_wr), .mask_sel(mask_sel), .mask_wdata(mask_wdata),
    .mask_rsel(mask_rsel), .mask_rdata(mask_rdata), .qry_done(qry_done),
    .qry_code(qry_code), .smi_req(smi_req), .sci_req(sci_req),
    .wake_req(wake_req)
  );

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    raise_vld = 0; raise_code = '0; clr_vld = 0; clr_bits = '0;
    qry_vld = 0; mask_wr = 0; mask_sel = 2'd3; mask_wdata = '0;
  endtask

  task automatic step();
    @(negedge clk);
    idle();
  endtask

  task automatic raise(int code);
    @(negedge clk); raise_vld = 1; raise_code = CW'(code);
    step();
  endtask

  task automatic wmask(int sel, logic [NEV-1:0] val);
    @(negedge clk); mask_wr = 1; mask_sel = 2'(sel); mask_wdata = val;
    step();
  endtask

  task automatic rmask(int sel, output logic [NEV-1:0] val);
    @(negedge clk); mask_rsel = 2'(sel);
    @(negedge clk); val = mask_rdata;
  endtask

  task automatic query(string req, int exp);
    @(negedge clk); qry_vld = 1;
    step();
    check(req, {63'd0, qry_done}, 64'd1);
    check(req, {58'd0, qry_code}, 64'(exp));
  endtask

  task automatic t_reset();
    logic [NEV-1:0] v;
    rst = 1; idle(); mask_rsel = 2'd0;
    repeat (3) @(negedge clk);
    rst = 0;
    check("R1 reqs", {61'd0, smi_req, sci_req, wake_req}, 64'd0);
    check("R1 done", {63'd0, qry_done}, 64'd0);
    for (int s = 0; s < 3; s++) begin
      rmask(s, v);
      check("R1 mask", 64'(v), 64'd0);
    end
    query("R1 empty", 0);
  endtask

  task automatic t_masks();
    logic [NEV-1:0] v;
    wmask(0, 32'h1234_5678);
    wmask(1, 32'h8000_0001);
    wmask(2, 32'h0F0F_0000);
    wmask(3, 32'hFFFF_FFFF);
    rmask(0, v); check("R3 smi", 64'(v), 64'h1234_5678);
    rmask(1, v); check("R3 sci", 64'(v), 64'h8000_0001);
    rmask(2, v); check("R3 wake", 64'(v), 64'h0F0F_0000);
    rmask(3, v); check("R3 none", 64'(v), 64'd0);
    wmask(0, '0); wmask(1, '0); wmask(2, '0);
  endtask

  task automatic t_order();
    raise(13); raise(3); raise(1);
    query("R5 first", 1);
    query("R5 second", 3);
    query("R5 third", 13);
    query("R6 empty", 0);
    query("R6 still empty", 0);
  endtask

  task automatic t_invalid();
    raise(0); raise(33); raise(63);
    wmask(1, 32'hFFFF_FFFF);
    check("R2 ignored codes", {63'd0, sci_req}, 64'd0);
    query("R2 ignored codes", 0);
    wmask(1, '0);
  endtask

  task automatic t_top_bit();
    raise(32);
    query("R9 top bit", 32);
    query("R9 drained", 0);
  endtask

  task automatic t_requests();
    wmask(0, 32'h0000_0004);
    wmask(1, 32'h0000_1000);
    wmask(2, 32'h0000_0001);
    @(negedge clk); raise_vld = 1; raise_code = CW'(3);
    step();
    check("R7 smi on", {63'd0, smi_req}, 64'd1);
    check("R7 sci off", {63'd0, sci_req}, 64'd0);
    check("R7 wake off", {63'd0, wake_req}, 64'd0);
    raise(13);
    check("R7 sci on", {63'd0, sci_req}, 64'd1);
    @(negedge clk); clr_vld = 1; clr_bits = 32'h0000_0004;
    step();
    check("R4 smi drop", {63'd0, smi_req}, 64'd0);
    check("R4 sci kept", {63'd0, sci_req}, 64'd1);
    wmask(1, '0);
    check("R7 sci masked", {63'd0, sci_req}, 64'd0);
    query("R4 remaining", 13);
    query("R4 empty", 0);
    wmask(0, '0); wmask(2, '0);
  endtask

  task automatic t_clear();
    raise(2); raise(5); raise(9); raise(20);
    @(negedge clk); clr_vld = 1; clr_bits = 32'h0008_0012;
    step();
    query("R4 clear keeps", 9);
    query("R4 clear done", 0);
  endtask

  task automatic t_collide();
    raise(5);
    @(negedge clk); raise_vld = 1; raise_code = CW'(5);
    clr_vld = 1; clr_bits = 32'h0000_0010;
    step();
    query("R8 raise beats clear", 5);
    raise(7);
    @(negedge clk); raise_vld = 1; raise_code = CW'(7); qry_vld = 1;
    step();
    check("R8 query code", {58'd0, qry_code}, 64'd7);
    query("R8 raise beats query", 7);
    query("R8 empty", 0);
  endtask

  initial begin
    #(200000 * 4);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_run + 1, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_masks();
    t_order();
    t_invalid();
    t_top_bit();
    t_requests();
    t_clear();
    t_collide();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule